// File: doc/BRIEF.md
# Timer Compare and Event Unit

This unit keeps a 16-bit compare value and checks it against an externally counted 16-bit timer on every clock. When the timer reaches the compare value, the unit does what a 4-bit mode register selects. It can set an output latch, clear that latch, only raise an interrupt flag, or fire a special event. The special event asks the timer to restart from zero and, when the converter is enabled, also sends a one-cycle start pulse to an external converter. In that mode the compare value acts as a programmable period for the timer.

Software loads the compare value and the mode through a small write port. The interrupt flag stays set until it is cleared through a dedicated input. The pin output follows the latch only while the output-enable input selects output. A match is edge-qualified, so one arrival of the timer at the compare value causes exactly one action.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the output latch, the interrupt flag, the timer-clear request and the converter start are all 0, and the mode is 4'b0000 (no compare action).
- R2: The comparison runs on every cycle whatever the cause. A timer that reaches the stored value triggers the action. So does a compare value written to equal the running timer. A write with wr_sel=0 loads wr_data into the compare value. A write with wr_sel=1 loads wr_data[3:0] into the mode.
- R3: A match acts once for each rising edge of equality. Equality only counts while tmr_run is 1. A timer held on the compare value does not retrigger. Each timer-clear pulse lasts exactly one cycle.
- R4: In mode 4'b1000 a match sets the output latch. In mode 4'b1001 a match clears it.
- R5: In mode 4'b1010 a match leaves the latch unchanged and sets the interrupt flag.
- R6: In mode 4'b1011 a match raises tmr_clear for one cycle, leaves the latch unchanged and sets the flag.
- R7: conv_start pulses together with tmr_clear only when conv_en was 1 in the match cycle.
- R8: For every mode code outside 4'b1000 to 4'b1011, a match changes neither the latch nor the flag and produces no pulse.
- R9: Each match in modes 4'b1000 to 4'b1011 sets cmp_flag. The flag stays set until flag_clr is 1. A match and a clear in the same cycle leave the flag set.
- R10: Writing zero to the mode register forces the latch low. This wins over a match in the same cycle.
- R11: pin_oe equals out_en. pin_o equals the latch while out_en is 1 and is 0 otherwise.
- R12: The action appears on the outputs after the clock edge that ends the first cycle of equality. A newly written compare value takes part in comparison from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the compare value, 1 selects the mode |
| wr_data | input | 16 | Write data |
| tmr_value | input | 16 | Current timer count |
| tmr_run | input | 1 | Timer is counting; qualifies equality |
| out_en | input | 1 | Pin direction: 1 means output |
| conv_en | input | 1 | Converter enabled; gates the start pulse |
| flag_clr | input | 1 | Clears the interrupt flag |
| pin_o | output | 1 | Pin level driven from the latch |
| pin_oe | output | 1 | Pin driver enable |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| tmr_clear | output | 1 | One-cycle request to restart the timer at zero |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
Two pairs of functions can land in the same cycle: a match arriving with a flag clear, and a match arriving with a zero write to the mode register. The bench provokes each pair by presenting the compare value on the timer in the same cycle as the clear or the write. It then judges the result from the flag and the pin after that edge: the flag must remain set, and the pin must be low. A sweep of all sixteen mode codes, with the latch preset both ways and the converter both enabled and disabled, compares every output against values computed from the mode rules.

// File: rtl/tcmp_pkg.sv
// Package: shared constants and helpers for the timer compare unit.
// Assumes a 4-bit mode field whose upper two bits 2'b10 mark compare modes.
package tcmp_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_SET     = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLR     = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_SWINT   = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

    // True when the code selects one of the four compare actions.
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m[MODE_W-1:MODE_W-2] == 2'b10);
    endfunction
endpackage

// File: rtl/tcmp_regs.sv
// Register file for the compare value and the mode.
// Assumes single-cycle writes; a zero mode write is flagged for the latch clear.
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              zero_wr
);
    logic mode_wr;

    // Decode a write to the mode register.
    always_comb mode_wr = wr_en && wr_sel;

    // Flag a write of zero to the whole mode register.
    always_comb zero_wr = mode_wr && (wr_data[MODE_W-1:0] == '0);

    // Hold the compare value and the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (wr_en) begin
            if (wr_sel) mode_q <= wr_data[MODE_W-1:0];
            else        cmp_q  <= wr_data;
        end
    end
endmodule

// File: rtl/tcmp_match_det.sv
// Equality detector with rising-edge qualification.
// Assumes the timer value is synchronous to clk; equality counts only while running.
module tcmp_match_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_run,
    output logic             fire
);
    logic eq_now;
    logic eq_prev;

    // Compare the timer with the stored value on every cycle.
    always_comb eq_now = tmr_run && (cmp_val == tmr_val);

    // Remember last cycle's equality for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_now;
    end

    // Report only the first cycle of equality.
    always_comb fire = eq_now && !eq_prev;
endmodule

// File: rtl/tcmp_action.sv
// Match action logic: output latch, sticky flag, timer-clear and converter pulses.
// Assumes fire is a single-cycle event; a zero mode write overrides latch actions.
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [MODE_W-1:0] mode,
    input  logic              zero_wr,
    input  logic              conv_en,
    input  logic              flag_clr,
    output logic              latch_q,
    output logic              flag_q,
    output logic              tclr_q,
    output logic              conv_q
);
    logic act;
    logic special;

    // Qualify the match with a compare mode.
    always_comb act = fire && mode_active(mode);

    // Detect a special event in this cycle.
    always_comb special = fire && (mode == MODE_SPECIAL);

    // Update the output latch; a zero mode write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                          latch_q <= 1'b0;
        else if (zero_wr)                    latch_q <= 1'b0;
        else if (fire && mode == MODE_SET)   latch_q <= 1'b1;
        else if (fire && mode == MODE_CLR)   latch_q <= 1'b0;
    end

    // Sticky interrupt flag; a match beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (act)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // One-cycle timer restart and converter start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclr_q <= 1'b0;
            conv_q <= 1'b0;
        end else begin
            tclr_q <= special;
            conv_q <= special && conv_en;
        end
    end
endmodule

// File: rtl/tcmp_unit.sv
// Top of the timer compare and event unit.
// Assumes an external timer that restarts at zero when tmr_clear is seen.
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] tmr_value,
    input  logic             tmr_run,
    input  logic             out_en,
    input  logic             conv_en,
    input  logic             flag_clr,
    output logic             pin_o,
    output logic             pin_oe,
    output logic             cmp_flag,
    output logic             tmr_clear,
    output logic             conv_start
);
    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              zero_wr;
    logic              fire;
    logic              latch_q;

    tcmp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmp_q(cmp_q), .mode_q(mode_q), .zero_wr(zero_wr)
    );

    tcmp_match_det #(.CNT_W(CNT_W)) det_i (
        .clk(clk), .rst_n(rst_n), .cmp_val(cmp_q), .tmr_val(tmr_value),
        .tmr_run(tmr_run), .fire(fire)
    );

    tcmp_action act_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .mode(mode_q),
        .zero_wr(zero_wr), .conv_en(conv_en), .flag_clr(flag_clr),
        .latch_q(latch_q), .flag_q(cmp_flag), .tclr_q(tmr_clear),
        .conv_q(conv_start)
    );

    // Drive the pin from the latch only when output is selected.
    always_comb begin
        pin_oe = out_en;
        pin_o  = out_en && latch_q;
    end
endmodule

// File: rtl/tcmp_unit_chk.sv
// Checker for tcmp_unit, attached by bind; observes ports and the match event.
// Assumes synchronous active-low reset.
module tcmp_unit_chk
    import tcmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fire,
    input logic [MODE_W-1:0] mode_q,
    input logic              cmp_flag,
    input logic              flag_clr,
    input logic              tmr_clear,
    input logic              conv_start,
    input logic              conv_en
);
    assert_match_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_active(mode_q)) |=> cmp_flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    assert_clear_from_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clear |-> ($past(mode_q) == MODE_SPECIAL));

    assert_conv_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (tmr_clear && $past(conv_en)));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clear |=> !tmr_clear);
endmodule

bind tcmp_unit tcmp_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .mode_q(mode_q),
    .cmp_flag(cmp_flag), .flag_clr(flag_clr), .tmr_clear(tmr_clear),
    .conv_start(conv_start), .conv_en(conv_en)
);

// File: tb/tcmp_unit_tb_top.sv
// Self-checking bench: mode sweep plus targeted same-cycle cases.
module tcmp_unit_tb_top;
    localparam logic [15:0] CMPV = 16'h2A5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] tmr_value = CMPV + 16'd1;
    logic        tmr_run = 1'b1, out_en = 1'b1, conv_en = 1'b0, flag_clr = 1'b0;
    logic        pin_o, pin_oe, cmp_flag, tmr_clear, conv_start;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    tcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tmr_value(tmr_value), .tmr_run(tmr_run), .out_en(out_en), .conv_en(conv_en),
        .flag_clr(flag_clr), .pin_o(pin_o), .pin_oe(pin_oe), .cmp_flag(cmp_flag),
        .tmr_clear(tmr_clear), .conv_start(conv_start)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        tick();
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic hit();
        @(negedge clk); tmr_value = CMPV;
        tick();
    endtask

    task automatic leave();
        @(negedge clk); tmr_value = CMPV + 16'd1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        check("R1", "pin_o", pin_o, 1'b0);
        check("R1", "cmp_flag", cmp_flag, 1'b0);
        check("R1", "tmr_clear", tmr_clear, 1'b0);
        check("R1", "conv_start", conv_start, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        tick();
        hit();
        check("R1", "flag with mode off", cmp_flag, 1'b0);
        leave();
        wr(1'b0, CMPV);

        // Sweep every mode code, latch preset and converter enable
        for (int m = 0; m < 16; m++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int ce = 0; ce < 2; ce++) begin
                    logic  act, exp_latch;
                    string rq;
                    if (pre == 1) begin wr(1'b1, 16'd8); hit(); leave(); end
                    else          wr(1'b1, 16'd0);
                    wr(1'b1, 16'(m));
                    clear_flag();
                    conv_en = ce[0];
                    act = (m >= 8 && m <= 11);
                    if (m == 0 || m == 9) exp_latch = 1'b0;
                    else if (m == 8)      exp_latch = 1'b1;
                    else                  exp_latch = pre[0];
                    rq = (m == 8 || m == 9) ? "R4" : (m == 10) ? "R5" : (m == 11) ? "R6" : "R8";
                    hit();
                    check(rq, "latch via pin_o", pin_o, exp_latch);
                    check(rq, "cmp_flag", cmp_flag, act);
                    check(rq, "tmr_clear", tmr_clear, m == 11);
                    check("R7", "conv_start", conv_start, (m == 11) && ce == 1);
                    leave();
                    check("R3", "tmr_clear one cycle", tmr_clear, 1'b0);
                    check("R7", "conv_start one cycle", conv_start, 1'b0);
                end
            end
        end
        conv_en = 1'b0;

        // R2 / R12: compare value written equal to the running timer
        wr(1'b1, 16'd10);
        clear_flag();
        @(negedge clk); tmr_value = 16'h0500;
        tick();
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0500;
        tick();
        check("R12", "flag not yet set", cmp_flag, 1'b0);
        @(negedge clk); wr_en = 1'b0;
        tick();
        check("R2", "flag after write match", cmp_flag, 1'b1);
        wr(1'b0, CMPV);
        leave();

        // R3: held equality and stopped timer do not retrigger
        clear_flag();
        hit();
        check("R3", "first match", cmp_flag, 1'b1);
        clear_flag();
        check("R3", "cleared while held", cmp_flag, 1'b0);
        tick();
        check("R3", "no retrigger while held", cmp_flag, 1'b0);
        @(negedge clk); tmr_run = 1'b0; tmr_value = CMPV + 16'd1;
        tick();
        @(negedge clk); tmr_value = CMPV;
        tick();
        check("R3", "stopped timer no match", cmp_flag, 1'b0);
        @(negedge clk); tmr_run = 1'b1;
        tick();
        check("R3", "match on restart", cmp_flag, 1'b1);
        leave();

        // R9: match and clear in the same cycle
        clear_flag();
        @(negedge clk); tmr_value = CMPV; flag_clr = 1'b1;
        tick();
        check("R9", "match beats clear", cmp_flag, 1'b1);
        @(negedge clk); flag_clr = 1'b0;
        tick();
        check("R9", "flag sticky", cmp_flag, 1'b1);
        leave();

        // R10: zero write beats a set-on-match in the same cycle
        wr(1'b1, 16'd8);
        hit(); leave();
        check("R10", "latch preset", pin_o, 1'b1);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0000; tmr_value = CMPV;
        tick();
        check("R10", "latch forced low", pin_o, 1'b0);
        @(negedge clk); wr_en = 1'b0;
        leave();

        // R11: pin follows latch only with output enabled
        wr(1'b1, 16'd8);
        hit(); leave();
        @(negedge clk); out_en = 1'b0;
        tick();
        check("R11", "pin_o disabled", pin_o, 1'b0);
        check("R11", "pin_oe disabled", pin_oe, 1'b0);
        @(negedge clk); out_en = 1'b1;
        tick();
        check("R11", "pin_o enabled", pin_o, 1'b1);
        check("R11", "pin_oe enabled", pin_oe, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule